// File: doc/BRIEF.md
# Receive Buffer Flow Controller

This block keeps a buffer-credit count for receive DMA channels and turns it into a pause request towards the packet source. Two neighbouring channels share one accounting slot. In this project that slot is called a pair, and channel `c` maps to pair `c >> 1`. Software adds credit by writing a buffer count to the pair's allocation register. The receive DMA removes one credit per descriptor it consumes by pulsing that pair's `consume` bit.

Each pair has a low and a high threshold. When the credit count falls to the low threshold or below it, the pair's `pause` output rises. The output falls again only once the count has climbed back to the high threshold or above. A typical setting is one third and two thirds of the ring size. An allocation write can also set a force flag, which holds the pause request low whatever the count is. A global enable gates every pair, and each pair has its own enable as well.

All inputs and outputs are plain control levels and pulses. `pause` is itself the back-pressure signal: the packet source is expected to stop delivering while it is high. No data passes through the block.

Top module: `rbfc_top`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, every `pause` bit is 0.
- R2: The register at byte address 0x00 holds the enables. Bit 0 is the global enable and bit p+1 enables pair p. A pair is active only when both bits are 1. An inactive pair drives `pause` low.
- R3: Pair p decodes three registers at `0x04 + 12p`, `0x08 + 12p` and `0x0C + 12p`. In that order they hold the low threshold, the high threshold and the allocation register. Thresholds use bits [CREDIT_W-1:0] of the write data and may be written at any time.
- R4: When an active pair's allocation register is written, the pair adds bits [CREDIT_W-1:0] of the data to its credit count. The count saturates at 2^CREDIT_W-1.
- R5: Each cycle in which an active pair's `consume` bit is 1 removes one credit. The count saturates at 0.
- R6: When the credit count is at or below the low threshold, `pause` goes to 1.
- R7: When the credit count is at or above the high threshold and above the low threshold, `pause` goes to 0. Strictly between the two thresholds, `pause` keeps its previous value.
- R8: Bit 31 of an allocation write sets the pair's force flag when it is 1 and clears it when it is 0. While the flag is set, `pause` stays 0.
- R9: While a pair is inactive, its allocation writes and `consume` pulses change neither its credit count nor its force flag.
- R10: The pairs are independent. Writes to one pair and `consume` pulses on one pair never change another pair's `pause`.
- R11: A change in credit shows on `pause` after the same clock edge that changes the count. An enable write or a force-flag change shows on `pause` one edge later than that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Write data |
| consume | input | NUM_PAIRS | One descriptor consumed by the receive DMA, one bit per pair |
| pause | output | NUM_PAIRS | Back-pressure request to the packet source, one bit per pair |

## Verification
A credit change, whether from an allocation write or a `consume` pulse, reaches `pause` at the rising edge that samples the stimulus. Writes to the enables and changes to the force flag take one further edge, because `pause` is computed from their registered values. Inputs are driven at the falling edge. After a credit stimulus the bench samples `pause` at the next falling edge. After an enable or force write it waits one more cycle, and it also checks the intermediate cycle to confirm that the extra edge is really there.

// File: rtl/rbfc_pkg.sv
package rbfc_pkg;
  // Register layout
  localparam int CFG_ADDR    = 0;
  localparam int PAIR_BASE   = 4;
  localparam int PAIR_STRIDE = 12;
  localparam int LO_OFS      = 0;
  localparam int HI_OFS      = 4;
  localparam int ALLOC_OFS   = 8;
  localparam int FORCE_BIT   = 31;
  localparam int DATA_W      = 32;

  function automatic int pair_reg_addr(input int pair, input int ofs);
    return PAIR_BASE + PAIR_STRIDE * pair + ofs;
  endfunction

  typedef enum logic [1:0] {
    PAIR_QUIET  = 2'd0,
    PAIR_ASSERT = 2'd1,
    PAIR_CLEAR  = 2'd2,
    PAIR_HOLD   = 2'd3
  } pause_act_e;
endpackage

// File: rtl/rbfc_regs.sv
module rbfc_regs
  import rbfc_pkg::*;
#(
  parameter int NUM_PAIRS = 4,
  parameter int CREDIT_W  = 8,
  parameter int ADDR_W    = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [ADDR_W-1:0]                   wr_addr,
  input  logic [DATA_W-1:0]                   wr_data,
  output logic [NUM_PAIRS-1:0]                pair_active,
  output logic [NUM_PAIRS-1:0][CREDIT_W-1:0]  thr_lo,
  output logic [NUM_PAIRS-1:0][CREDIT_W-1:0]  thr_hi,
  output logic [NUM_PAIRS-1:0]                alloc_we
);
  localparam int CFG_W = NUM_PAIRS + 1;

  logic [CFG_W-1:0] cfg_q;
  logic             cfg_hit;
  logic             unused_data;

  assign unused_data = ^wr_data;
  assign cfg_hit     = wr_en && (wr_addr == ADDR_W'(CFG_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (cfg_hit) cfg_q <= wr_data[CFG_W-1:0];
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    localparam int LO_A = pair_reg_addr(p, LO_OFS);
    localparam int HI_A = pair_reg_addr(p, HI_OFS);
    localparam int AL_A = pair_reg_addr(p, ALLOC_OFS);

    logic lo_hit, hi_hit;
    assign lo_hit      = wr_en && (wr_addr == ADDR_W'(LO_A));
    assign hi_hit      = wr_en && (wr_addr == ADDR_W'(HI_A));
    assign alloc_we[p] = wr_en && (wr_addr == ADDR_W'(AL_A));
    assign pair_active[p] = cfg_q[0] & cfg_q[p+1];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        thr_lo[p] <= '0;
        thr_hi[p] <= '0;
      end else begin
        if (lo_hit) thr_lo[p] <= wr_data[CREDIT_W-1:0];
        if (hi_hit) thr_hi[p] <= wr_data[CREDIT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/rbfc_credit.sv
module rbfc_credit
  import rbfc_pkg::*;
#(
  parameter int CREDIT_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                active,
  input  logic                alloc_we,
  input  logic [CREDIT_W-1:0] alloc_cnt,
  input  logic                alloc_force,
  input  logic                consume,
  input  logic [CREDIT_W-1:0] thr_lo,
  input  logic [CREDIT_W-1:0] thr_hi,
  output logic                pause
);
  localparam logic [CREDIT_W-1:0] CREDIT_MAX = {CREDIT_W{1'b1}};

  logic [CREDIT_W-1:0] credit_q, credit_d;
  logic [CREDIT_W:0]   sum;
  logic                force_q, force_d;
  logic                take_alloc, take_one;
  logic                pause_q, pause_d;
  pause_act_e          act;

  assign take_alloc = active && alloc_we;
  assign take_one   = active && consume;

  // Credit update: add, remove one, clamp at both ends
  always_comb begin
    sum = {1'b0, credit_q} + (take_alloc ? {1'b0, alloc_cnt} : '0);
    if (take_one && (sum != '0)) sum = sum - 1'b1;
    credit_d = sum[CREDIT_W] ? CREDIT_MAX : sum[CREDIT_W-1:0];
    force_d  = take_alloc ? alloc_force : force_q;
  end

  // Hysteresis decision on the new count, gated by registered enable/force
  always_comb begin
    if (!active || force_q)        act = PAIR_QUIET;
    else if (credit_d <= thr_lo)   act = PAIR_ASSERT;
    else if (credit_d >= thr_hi)   act = PAIR_CLEAR;
    else                           act = PAIR_HOLD;
    unique case (act)
      PAIR_ASSERT: pause_d = 1'b1;
      PAIR_HOLD:   pause_d = pause_q;
      default:     pause_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      credit_q <= '0;
      force_q  <= 1'b0;
      pause_q  <= 1'b0;
    end else begin
      credit_q <= credit_d;
      force_q  <= force_d;
      pause_q  <= pause_d;
    end
  end

  assign pause = pause_q;
endmodule

// File: rtl/rbfc_top.sv
module rbfc_top
  import rbfc_pkg::*;
#(
  parameter int NUM_PAIRS = 4,
  parameter int CREDIT_W  = 8,
  parameter int ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [NUM_PAIRS-1:0] consume,
  output logic [NUM_PAIRS-1:0] pause
);
  logic [NUM_PAIRS-1:0]               pair_active;
  logic [NUM_PAIRS-1:0][CREDIT_W-1:0] thr_lo, thr_hi;
  logic [NUM_PAIRS-1:0]               alloc_we;

  rbfc_regs #(
    .NUM_PAIRS(NUM_PAIRS), .CREDIT_W(CREDIT_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pair_active(pair_active), .thr_lo(thr_lo), .thr_hi(thr_hi),
    .alloc_we(alloc_we)
  );

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_credit
    rbfc_credit #(.CREDIT_W(CREDIT_W)) u_credit (
      .clk(clk), .rst_n(rst_n),
      .active(pair_active[p]),
      .alloc_we(alloc_we[p]),
      .alloc_cnt(wr_data[CREDIT_W-1:0]),
      .alloc_force(wr_data[FORCE_BIT]),
      .consume(consume[p]),
      .thr_lo(thr_lo[p]), .thr_hi(thr_hi[p]),
      .pause(pause[p])
    );
  end
endmodule

// File: rtl/rbfc_checker.sv
module rbfc_checker
  import rbfc_pkg::*;
#(
  parameter int NUM_PAIRS = 4,
  parameter int ADDR_W    = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [ADDR_W-1:0]    wr_addr,
  input logic [DATA_W-1:0]    wr_data,
  input logic [NUM_PAIRS-1:0] consume,
  input logic [NUM_PAIRS-1:0] pause
);
  logic [NUM_PAIRS:0]   cfg_sh;
  logic [NUM_PAIRS-1:0] en_sh, force_sh;
  logic                 unused_in;

  assign unused_in = ^consume;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_sh <= '0;
    else if (wr_en && wr_addr == ADDR_W'(CFG_ADDR)) cfg_sh <= wr_data[NUM_PAIRS:0];
  end

  // R1: outputs idle while in reset
  always @(posedge clk) begin
    if (!rst_n) a_r1_reset_clear: assert (pause == '0);
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_chk
    localparam int AL_A = pair_reg_addr(p, ALLOC_OFS);
    assign en_sh[p] = cfg_sh[0] & cfg_sh[p+1];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) force_sh[p] <= 1'b0;
      else if (wr_en && wr_addr == ADDR_W'(AL_A) && en_sh[p])
        force_sh[p] <= wr_data[FORCE_BIT];
    end

    a_r2_inactive_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !en_sh[p] |=> !pause[p]);
    a_r8_force_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      force_sh[p] |=> !pause[p]);
    a_r6_rise_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pause[p]) |-> ($past(en_sh[p]) && !$past(force_sh[p])));
  end
endmodule

bind rbfc_top rbfc_checker #(.NUM_PAIRS(NUM_PAIRS), .ADDR_W(ADDR_W)) u_rbfc_checker (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .consume(consume), .pause(pause)
);

// File: tb/rbfc_top_bench.sv
module rbfc_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [31:0]   wr_data;
  logic [NP-1:0] consume;
  logic [NP-1:0] pause;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rbfc_top #(.NUM_PAIRS(NP), .CREDIT_W(8), .ADDR_W(AW)) u_rbfc_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .consume(consume), .pause(pause)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: pause actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    wr_en = 1'b1; wr_addr = AW'(addr); wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic eat(input int pair, input int n);
    for (int i = 0; i < n; i++) begin
      consume = NP'(1) << pair;
      @(negedge clk);
      consume = '0;
    end
  endtask

  task automatic t_reset;
    chk("R1 reset pair0", pause[0], 1'b0);
    chk("R1 reset all", |pause, 1'b0);
  endtask

  task automatic t_enable;
    wr(32'h04, 3); wr(32'h08, 6);
    wr(32'h00, 32'h2);          // pair0 bit only, global off
    repeat (2) @(negedge clk);
    chk("R2 global off keeps pause low", pause[0], 1'b0);
    wr(32'h0C, 5);              // R9: ignored while inactive
    wr(32'h00, 32'h3);
    chk("R11 enable not yet visible", pause[0], 1'b0);
    @(negedge clk);
    chk("R9 ignored credit leaves count 0 so pause", pause[0], 1'b1);
    chk("R10 pair1 untouched", pause[1], 1'b0);
  endtask

  task automatic t_hysteresis;
    wr(32'h0C, 4);
    chk("R7 between thresholds holds high", pause[0], 1'b1);
    wr(32'h0C, 2);
    chk("R7 reach high threshold clears", pause[0], 1'b0);
    eat(0, 2);
    chk("R7 between thresholds holds low", pause[0], 1'b0);
    eat(0, 1);
    chk("R6 reach low threshold asserts", pause[0], 1'b1);
  endtask

  task automatic t_floor;
    eat(0, 5);                  // 3 -> 0, two extra pulses
    wr(32'h0C, 6);
    chk("R5 count floors at zero", pause[0], 1'b0);
  endtask

  task automatic t_ceiling;
    wr(32'h0C, 255);            // 6 + 255 clamps to 255
    eat(0, 250);
    chk("R4 count clamps at max", pause[0], 1'b0);
    eat(0, 2);
    chk("R4 drained from max to low", pause[0], 1'b1);
  endtask

  task automatic t_force;
    wr(32'h0C, 32'h8000_0000);
    chk("R11 force one edge late", pause[0], 1'b1);
    @(negedge clk);
    chk("R8 force drops pause", pause[0], 1'b0);
    eat(0, 3);
    chk("R8 force holds at zero credit", pause[0], 1'b0);
    wr(32'h0C, 2);
    @(negedge clk);
    chk("R8 force cleared resumes pause", pause[0], 1'b1);
  endtask

  task automatic t_pairs;
    wr(32'h1C, 1); wr(32'h20, 2);
    wr(32'h24, 2);              // pair2 inactive, ignored
    wr(32'h00, 32'hB);
    @(negedge clk);
    chk("R3 pair2 low threshold decoded", pause[2], 1'b1);
    chk("R10 pair0 unchanged", pause[0], 1'b1);
    wr(32'h24, 2);
    chk("R3 pair2 allocation decoded", pause[2], 1'b0);
    chk("R10 pair0 unaffected by pair2 write", pause[0], 1'b1);
    eat(2, 1);
    chk("R6 pair2 drops to low threshold", pause[2], 1'b1);
  endtask

  task automatic t_global;
    wr(32'h00, 32'hA);
    @(negedge clk);
    chk("R2 global off clears pair0", pause[0], 1'b0);
    chk("R2 global off clears pair2", pause[2], 1'b0);
    wr(32'h24, 1);              // ignored
    wr(32'h00, 32'hB);
    @(negedge clk);
    chk("R9 inactive allocation ignored", pause[2], 1'b1);
  endtask

  initial begin
    rst_n = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; consume = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_hysteresis();
    t_floor();
    t_ceiling();
    t_force();
    t_pairs();
    t_global();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end
endmodule